// File: doc/BRIEF.md
# Channel Byte Packing Buffer

This block sits between a byte-wide peripheral port and a 32-bit big-endian word memory on behalf of one I/O channel. It is loaded with a transfer descriptor: start address, byte count, command code, protection key and three flags (chain-data, suppress-length, skip). On an output command it fetches a word and hands its bytes to the device one at a time. On an input command it merges incoming bytes into a buffered copy of the target word (read-modify-write) and writes the word back when it leaves that word. Input can run with ascending or descending addresses. Skip mode consumes bytes without touching memory.

When the count runs out, the block flushes any pending partial word. It then either asks for the next descriptor through a request/acknowledge handshake (chain-data set) or raises channel end. Every memory access first passes an address gate. This gate refuses out-of-range addresses and accesses that the storage key does not allow, and ends the transfer with an error flag.

Top module: `chan_pack_buf`

## Requirements
- R1: After reset no memory request is pending and channel end, chain request, both error flags, incorrect length, device output valid and device input ready are all low.
- R2: For an output command (command bit 0 = 1), bytes come out in ascending byte-address order starting at the loaded address. The byte at address a is lane a mod 4 of its word, where lane n is word bits 31-8n down to 24-8n. Exactly `count` bytes are delivered, then channel end rises. A byte stays stable while the device does not take it.
- R3: For a forward input command (bit 0 = 0, low nibble not 0xC), byte k is stored at address start+k. All other bytes of the touched words keep their previous memory value.
- R4: For a backward input command (low nibble 0xC), byte k is stored at address start−k, crossing into the preceding word after lane 0. Other bytes are preserved.
- R5: With the skip flag set on an input command, every offered byte up to the count is consumed, no memory write is issued, and channel end follows.
- R6: When the count reaches zero with chain-data set, any partial word is written first. Then a chain request is held without channel end. After the acknowledge, the transfer continues at the newly loaded address and count.
- R7: After channel end of an input command, a further byte offered by the device sets incorrect length unless suppress-length is set. The byte is never accepted.
- R8: With a nonzero key the access is refused, with the protection error flag set and no memory request, when any of these holds:
  - protection is disabled;
  - a write targets a 2 KB block whose table key differs;
  - a read targets a block whose key differs and whose fetch-protect bit is set.
  A read of a block with a different key and fetch-protect clear is allowed.
- R9: An access at a byte address not below the memory size sets the program check flag and issues no memory request.
- R10: A descriptor loaded with a count of zero sets the program check flag without any memory access.
- R11: A memory request keeps its address, write enable and data stable until acknowledged, and only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load a new descriptor (taken when idle or finished) |
| chain_ack | input | 1 | Next descriptor present on the load bus |
| ld_addr | input | ADDR_W | Descriptor byte address |
| ld_key | input | KEY_W | Descriptor protection key |
| ld_cnt | input | CNT_W | Descriptor byte count |
| ld_cmd | input | 4 | Command code: bit 0 = output, 0xC = backward input |
| ld_cd | input | 1 | Chain-data flag |
| ld_sli | input | 1 | Suppress incorrect length |
| ld_skip | input | 1 | Skip mode: input bytes are not stored |
| prot_en | input | 1 | Storage protection enabled |
| dev_out_valid | output | 1 | Output byte available |
| dev_out_ready | input | 1 | Device takes the output byte |
| dev_out_data | output | 8 | Output byte |
| dev_in_valid | input | 1 | Device offers an input byte |
| dev_in_ready | output | 1 | Block accepts the input byte |
| dev_in_data | input | 8 | Input byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word, valid with mem_ack |
| mem_ack | input | 1 | Access done |
| key_blk | output | ADDR_W-BLK_SHIFT | Protection block index of the current address |
| blk_key | input | KEY_W | Table key of that block |
| blk_fetch_prot | input | 1 | Fetch-protect bit of that block |
| chain_req | output | 1 | Next descriptor wanted |
| chan_end | output | 1 | Transfer finished normally |
| len_err | output | 1 | Incorrect length |
| prot_err | output | 1 | Protection refusal |
| prog_chk | output | 1 | Address range or zero-count error |

## Verification
Two events can meet in one cycle. The count reaching zero and a pending write-back of a partially filled word coincide at every odd-length or mid-word input transfer. The same holds for chained input, where the flush must precede the chain request. The bench provokes this with counts and start lanes that end inside a word and with a chained pair split mid-word, under random memory and device stalls. It judges the result by comparing the whole memory image against a reference copy updated byte by byte. A second collision is a device byte offered in the same cycle the transfer ends; it must raise incorrect length rather than be stored, which a memory comparison after over-supplied input confirms.

// File: rtl/chan_pack_pkg.sv
`timescale 1ns/1ps
package chan_pack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_CHAIN,
        ST_DONE
    } pack_state_e;

    typedef enum logic [1:0] {
        GATE_OK,
        GATE_PROT,
        GATE_RANGE
    } gate_e;

    typedef struct packed {
        logic cd;
        logic sli;
        logic skip;
    } ccw_flags_t;

    localparam logic [3:0] CMD_BACKWARD = 4'hC;

    // lane 0 is the most significant byte
    function automatic logic [7:0] lane_get(logic [31:0] w, logic [1:0] lane);
        case (lane)
            2'd0:    return w[31:24];
            2'd1:    return w[23:16];
            2'd2:    return w[15:8];
            default: return w[7:0];
        endcase
    endfunction

    function automatic logic [31:0] lane_put(logic [31:0] w, logic [1:0] lane, logic [7:0] b);
        logic [31:0] r;
        r = w;
        case (lane)
            2'd0:    r[31:24] = b;
            2'd1:    r[23:16] = b;
            2'd2:    r[15:8]  = b;
            default: r[7:0]   = b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/chan_pack_gate.sv
`timescale 1ns/1ps
module chan_pack_gate
    import chan_pack_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int KEY_W     = 4,
    parameter int MEM_BYTES = 65536
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [KEY_W-1:0]  key,
    input  logic              write,
    input  logic              prot_en,
    input  logic [KEY_W-1:0]  blk_key,
    input  logic              blk_fetch_prot,
    output gate_e             verdict
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_BYTES);

    always_comb begin
        verdict = GATE_OK;
        if ({1'b0, addr} >= LIMIT)
            verdict = GATE_RANGE;
        else if (key != '0) begin
            if (!prot_en)
                verdict = GATE_PROT;
            else if (blk_key != key && (write || blk_fetch_prot))
                verdict = GATE_PROT;
        end
    end
endmodule

// File: rtl/chan_pack_lanes.sv
`timescale 1ns/1ps
module chan_pack_lanes
    import chan_pack_pkg::*;
(
    input  logic [31:0] word_in,
    input  logic [1:0]  lane,
    input  logic [7:0]  byte_in,
    output logic [7:0]  byte_out,
    output logic [31:0] word_out
);
    always_comb begin
        byte_out = lane_get(word_in, lane);
        word_out = lane_put(word_in, lane, byte_in);
    end
endmodule

// File: rtl/chan_pack_buf.sv
`timescale 1ns/1ps
module chan_pack_buf
    import chan_pack_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int CNT_W     = 16,
    parameter int KEY_W     = 4,
    parameter int MEM_BYTES = 65536,
    parameter int BLK_SHIFT = 11
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  chain_ack,
    input  logic [ADDR_W-1:0]     ld_addr,
    input  logic [KEY_W-1:0]      ld_key,
    input  logic [CNT_W-1:0]      ld_cnt,
    input  logic [3:0]            ld_cmd,
    input  logic                  ld_cd,
    input  logic                  ld_sli,
    input  logic                  ld_skip,
    input  logic                  prot_en,
    output logic                  dev_out_valid,
    input  logic                  dev_out_ready,
    output logic [7:0]            dev_out_data,
    input  logic                  dev_in_valid,
    output logic                  dev_in_ready,
    input  logic [7:0]            dev_in_data,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-3:0]     mem_addr,
    output logic [31:0]           mem_wdata,
    input  logic [31:0]           mem_rdata,
    input  logic                  mem_ack,
    output logic [ADDR_W-BLK_SHIFT-1:0] key_blk,
    input  logic [KEY_W-1:0]      blk_key,
    input  logic                  blk_fetch_prot,
    output logic                  chain_req,
    output logic                  chan_end,
    output logic                  len_err,
    output logic                  prot_err,
    output logic                  prog_chk
);
    localparam int WA_W = ADDR_W - 2;

    pack_state_e       state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [KEY_W-1:0]  key_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [3:0]        cmd_q;
    ccw_flags_t        flg_q;
    logic [31:0]       buf_q;
    logic [1:0]        lane_q;
    logic              full_q, dirty_q;
    logic              end_q, len_q, prot_q, pchk_q;

    logic is_out, backward, cnt_zero, running;
    logic do_flush, do_fetch, do_finish, access, skip_act;
    logic [ADDR_W-1:0] word_next, word_prev;
    logic [7:0]  lane_byte;
    logic [31:0] merged;
    gate_e       verdict;

    assign is_out    = cmd_q[0];
    assign backward  = (cmd_q == CMD_BACKWARD);
    assign cnt_zero  = (cnt_q == '0);
    assign running   = (state_q == ST_RUN);
    assign skip_act  = flg_q.skip && !is_out;

    // a written-to word leaves the buffer when its lanes run out or the count ends
    assign do_flush  = !is_out && dirty_q && (cnt_zero || !full_q);
    assign do_fetch  = !cnt_zero && !full_q && !do_flush && !skip_act;
    assign do_finish = cnt_zero && !do_flush;
    assign access    = running && (do_flush || do_fetch);

    assign word_next = {addr_q[ADDR_W-1:2] + 1'b1, 2'b00};
    assign word_prev = {addr_q[ADDR_W-1:2], 2'b00} - 1'b1;

    chan_pack_gate #(
        .ADDR_W(ADDR_W), .KEY_W(KEY_W), .MEM_BYTES(MEM_BYTES)
    ) u_gate (
        .addr(addr_q), .key(key_q), .write(do_flush), .prot_en(prot_en),
        .blk_key(blk_key), .blk_fetch_prot(blk_fetch_prot), .verdict(verdict)
    );

    chan_pack_lanes u_lanes (
        .word_in(buf_q), .lane(lane_q), .byte_in(dev_in_data),
        .byte_out(lane_byte), .word_out(merged)
    );

    assign mem_req       = access && (verdict == GATE_OK);
    assign mem_we        = do_flush;
    assign mem_addr      = addr_q[ADDR_W-1:2];
    assign mem_wdata     = buf_q;
    assign key_blk       = addr_q[ADDR_W-1:BLK_SHIFT];
    assign dev_out_valid = running && is_out && !cnt_zero && full_q;
    assign dev_out_data  = lane_byte;
    assign dev_in_ready  = running && !is_out && !cnt_zero && !do_flush && (flg_q.skip || full_q);
    assign chain_req     = (state_q == ST_CHAIN);
    assign chan_end      = end_q;
    assign len_err       = len_q;
    assign prot_err      = prot_q;
    assign prog_chk      = pchk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            key_q   <= '0;
            cnt_q   <= '0;
            cmd_q   <= '0;
            flg_q   <= '0;
            buf_q   <= '0;
            lane_q  <= '0;
            full_q  <= 1'b0;
            dirty_q <= 1'b0;
            end_q   <= 1'b0;
            len_q   <= 1'b0;
            prot_q  <= 1'b0;
            pchk_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (state_q == ST_DONE && end_q && !is_out && dev_in_valid && !flg_q.sli)
                        len_q <= 1'b1;
                    if (start) begin
                        addr_q  <= ld_addr;
                        key_q   <= ld_key;
                        cnt_q   <= ld_cnt;
                        cmd_q   <= ld_cmd;
                        flg_q   <= '{cd: ld_cd, sli: ld_sli, skip: ld_skip};
                        full_q  <= 1'b0;
                        dirty_q <= 1'b0;
                        end_q   <= 1'b0;
                        len_q   <= 1'b0;
                        prot_q  <= 1'b0;
                        pchk_q  <= (ld_cnt == '0);
                        state_q <= (ld_cnt == '0) ? ST_DONE : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (access && verdict != GATE_OK) begin
                        prot_q  <= (verdict == GATE_PROT);
                        pchk_q  <= (verdict == GATE_RANGE);
                        state_q <= ST_DONE;
                    end else if (mem_req && mem_ack) begin
                        if (do_flush) begin
                            dirty_q <= 1'b0;
                            full_q  <= 1'b0;
                            if (!cnt_zero)
                                addr_q <= backward ? word_prev : word_next;
                        end else begin
                            buf_q  <= mem_rdata;
                            lane_q <= addr_q[1:0];
                            full_q <= 1'b1;
                            if (is_out)
                                addr_q <= word_next;
                        end
                    end else if (do_finish) begin
                        if (flg_q.cd)
                            state_q <= ST_CHAIN;
                        else begin
                            end_q   <= 1'b1;
                            state_q <= ST_DONE;
                        end
                    end else if (dev_out_valid && dev_out_ready) begin
                        cnt_q  <= cnt_q - 1'b1;
                        lane_q <= lane_q + 1'b1;
                        if (lane_q == 2'd3)
                            full_q <= 1'b0;
                    end else if (dev_in_ready && dev_in_valid) begin
                        cnt_q <= cnt_q - 1'b1;
                        if (flg_q.skip)
                            addr_q <= backward ? addr_q - 1'b1 : addr_q + 1'b1;
                        else begin
                            buf_q   <= merged;
                            dirty_q <= 1'b1;
                            if (backward) begin
                                if (lane_q == 2'd0) full_q <= 1'b0;
                                else                lane_q <= lane_q - 1'b1;
                            end else begin
                                if (lane_q == 2'd3) full_q <= 1'b0;
                                else                lane_q <= lane_q + 1'b1;
                            end
                        end
                    end
                end
                ST_CHAIN: begin
                    if (chain_ack) begin
                        addr_q  <= ld_addr;
                        cnt_q   <= ld_cnt;
                        flg_q   <= '{cd: ld_cd, sli: ld_sli, skip: ld_skip};
                        full_q  <= 1'b0;
                        dirty_q <= 1'b0;
                        pchk_q  <= (ld_cnt == '0);
                        state_q <= (ld_cnt == '0) ? ST_DONE : ST_RUN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/chan_pack_buf_chk.sv
`timescale 1ns/1ps
module chan_pack_buf_chk #(
    parameter int WA_W = 22
) (
    input logic            clk,
    input logic            rst,
    input logic            mem_req,
    input logic            mem_ack,
    input logic            mem_we,
    input logic [WA_W-1:0] mem_addr,
    input logic [31:0]     mem_wdata,
    input logic            dev_out_valid,
    input logic            dev_out_ready,
    input logic [7:0]      dev_out_data,
    input logic            dev_in_ready,
    input logic            chain_req,
    input logic            chan_end,
    input logic            prot_err,
    input logic            prog_chk,
    input logic            skip_act
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        dev_out_valid && !dev_out_ready |=> dev_out_valid && $stable(dev_out_data)); // R2

    AST_END_QUIET: assert property (@(posedge clk) disable iff (rst)
        chan_end |-> !mem_req && !dev_in_ready && !dev_out_valid); // R7

    AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        skip_act |-> !(mem_req && mem_we)); // R5

    AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (prot_err || prog_chk) |-> !mem_req); // R8

    AST_CHAIN_NO_END: assert property (@(posedge clk) disable iff (rst)
        chain_req |-> !chan_end && !mem_req && !dev_in_ready); // R6
endmodule

bind chan_pack_buf chan_pack_buf_chk #(.WA_W(ADDR_W-2)) u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .dev_out_valid(dev_out_valid),
    .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
    .dev_in_ready(dev_in_ready), .chain_req(chain_req), .chan_end(chan_end),
    .prot_err(prot_err), .prog_chk(prog_chk), .skip_act(skip_act)
);

// File: tb/chan_pack_buf_test.sv
`timescale 1ns/1ps
module chan_pack_buf_test;
    localparam int ADDR_W = 24;
    localparam int MEMB   = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic start = 0, chain_ack = 0, ld_cd = 0, ld_sli = 0, ld_skip = 0, prot_en = 0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [3:0]  ld_key = '0;
    logic [15:0] ld_cnt = '0;
    logic [3:0]  ld_cmd = '0;
    logic dev_out_valid, dev_out_ready = 0, dev_in_valid = 0, dev_in_ready;
    logic [7:0] dev_out_data, dev_in_data = '0;
    logic mem_req, mem_we, mem_ack = 0;
    logic [ADDR_W-3:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic [ADDR_W-12:0] key_blk;
    logic [3:0] blk_key;
    logic blk_fetch_prot;
    logic chain_req, chan_end, len_err, prot_err, prog_chk;

    logic [31:0] mem [1024];
    logic [31:0] refm[1024];
    logic [3:0]  bkey[2];
    logic        bfp[2];
    logic [7:0]  src[64];
    logic [7:0]  got[64];
    int src_n = 0, src_p = 0, ngot = 0, acc_cnt = 0, wr_cnt = 0;
    int n_chk = 0, n_fail = 0;

    assign blk_key        = bkey[key_blk[0]];
    assign blk_fetch_prot = bfp[key_blk[0]];

    chan_pack_buf #(.MEM_BYTES(MEMB)) uut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory responder: random latency, one request at a time
    initial forever begin
        @(negedge clk);
        mem_ack = 0;
        if (mem_req && ($urandom % 3) != 0) begin
            mem_ack = 1;
            acc_cnt++;
            if (mem_we) begin
                mem[mem_addr[9:0]] = mem_wdata;
                wr_cnt++;
            end else
                mem_rdata = mem[mem_addr[9:0]];
        end
    end

    // device responders
    initial forever begin
        @(negedge clk);
        dev_out_ready = ($urandom % 4) != 0;
        if (dev_out_valid && dev_out_ready) begin
            got[ngot] = dev_out_data;
            ngot++;
        end
    end

    initial forever begin
        @(negedge clk);
        dev_in_valid = 0;
        if (src_p < src_n && ($urandom % 4) != 0) begin
            dev_in_valid = 1;
            dev_in_data  = src[src_p];
            if (dev_in_ready) src_p++;
        end
    end

    function automatic logic [7:0] rb(int a);
        return 8'(refm[a >> 2] >> (8 * (3 - (a & 3))));
    endfunction

    task automatic wb(int a, logic [7:0] b);
        int sh;
        sh = 8 * (3 - (a & 3));
        refm[a >> 2] = (refm[a >> 2] & ~(32'hFF << sh)) | (32'(b) << sh);
    endtask

    task automatic launch(int a, int c, logic [3:0] cmd, logic cd, logic sli, logic skip, logic [3:0] key);
        @(negedge clk);
        ld_addr = ADDR_W'(a); ld_cnt = 16'(c); ld_cmd = cmd;
        ld_cd = cd; ld_sli = sli; ld_skip = skip; ld_key = key;
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done(string tag);
        int t;
        t = 0;
        while (!(chan_end || prot_err || prog_chk) && t < 4000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 4000) chk({tag, " watchdog"}, 0, 1);
    endtask

    task automatic cmp_mem(string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== refm[i]) bad++;
        chk({tag, " memory image"}, 32'(bad), 0);
    endtask

    task automatic run_out(string tag, int a, int c);
        ngot = 0;
        launch(a, c, 4'h1, 0, 0, 0, 4'h0);
        wait_done(tag);
        repeat (2) @(negedge clk);
        chk({tag, " chan_end"}, 32'(chan_end), 1);
        chk({tag, " byte count"}, 32'(ngot), 32'(c));
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < c; i++) if (got[i] !== rb(a + i)) bad++;
            chk({tag, " byte order"}, 32'(bad), 0);
        end
    endtask

    task automatic run_in(string tag, int a, int c, bit bwd, bit skip, bit sli, int extra);
        for (int i = 0; i < c + extra; i++) src[i] = 8'($urandom);
        if (!skip)
            for (int i = 0; i < c; i++) wb(bwd ? a - i : a + i, src[i]);
        src_p = 0; src_n = c + extra;
        launch(a, c, bwd ? 4'hC : 4'h2, 0, sli, skip, 4'h0);
        wait_done(tag);
        repeat (10) @(negedge clk);
        chk({tag, " chan_end"}, 32'(chan_end), 1);
        chk({tag, " bytes taken"}, 32'(src_p), 32'(c));
        cmp_mem(tag);
        src_n = 0; src_p = 0;
    endtask

    initial begin
        #(8 * 200000);
        chk("watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w0, a, c, d;
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) begin
            mem[i]  = 32'h5A3C0000 ^ (32'(i) * 32'h01030507);
            refm[i] = mem[i];
        end
        bkey[0] = 4'h3; bfp[0] = 1'b0;
        bkey[1] = 4'h5; bfp[1] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 flags", {28'd0, chan_end, chain_req, prot_err, prog_chk}, 0);
        chk("R1 dev side", {30'd0, dev_in_ready, dev_out_valid}, 0);
        chk("R1 len_err", 32'(len_err), 0);

        run_out("R2 mid-word start", 32'h101, 6);
        run_out("R2 aligned", 32'h1F0, 9);
        run_in("R3 forward", 32'h202, 7, 0, 0, 1, 0);
        run_in("R3 single byte", 32'h2A3, 1, 0, 0, 1, 0);
        run_in("R4 backward", 32'h305, 6, 1, 0, 1, 0);
        run_in("R4 backward long", 32'h343, 11, 1, 0, 1, 0);

        // R5 skip: consumes bytes, writes nothing
        w0 = wr_cnt;
        run_in("R5 skip", 32'h380, 5, 0, 1, 1, 0);
        chk("R5 no writes", 32'(wr_cnt - w0), 0);

        // R6 chained input split mid-word
        for (int i = 0; i < 5; i++) src[i] = 8'($urandom);
        for (int i = 0; i < 3; i++) wb(32'h601 + i, src[i]);
        for (int i = 3; i < 5; i++) wb(32'h640 + i - 3, src[i]);
        src_p = 0; src_n = 5;
        launch(32'h601, 3, 4'h2, 1, 1, 0, 4'h0);
        d = 0;
        while (!chain_req && d < 2000) begin @(negedge clk); d++; end
        chk("R6 chain request", 32'(chain_req), 1);
        chk("R6 no end while chaining", 32'(chan_end), 0);
        ld_addr = 24'h640; ld_cnt = 16'd2; ld_cd = 0; chain_ack = 1;
        @(negedge clk);
        chain_ack = 0;
        wait_done("R6");
        repeat (4) @(negedge clk);
        chk("R6 chan_end", 32'(chan_end), 1);
        cmp_mem("R6 chained");
        src_n = 0; src_p = 0;

        // R7 over-supplied input
        run_in("R7 extra no sli", 32'h500, 3, 0, 0, 0, 2);
        chk("R7 len_err set", 32'(len_err), 1);
        run_in("R7 extra with sli", 32'h520, 3, 0, 0, 1, 2);
        chk("R7 len_err suppressed", 32'(len_err), 0);

        // R8 protection
        w0 = acc_cnt;
        prot_en = 0;
        src_p = 0; src_n = 0;
        launch(32'h100, 2, 4'h2, 0, 1, 0, 4'h3);
        wait_done("R8a");
        chk("R8 refused with protection off", 32'(prot_err), 1);
        chk("R8 no access", 32'(acc_cnt - w0), 0);
        prot_en = 1;
        for (int i = 0; i < 2; i++) src[i] = 8'($urandom);
        wb(32'h140, src[0]); wb(32'h141, src[1]);
        src_p = 0; src_n = 2;
        launch(32'h140, 2, 4'h2, 0, 1, 0, 4'h3);
        wait_done("R8b");
        chk("R8 matching key accepted", {30'd0, prot_err, chan_end}, 1);
        cmp_mem("R8 matching key");
        w0 = wr_cnt;
        src[0] = 8'h77; src[1] = 8'h66; src_p = 0; src_n = 2;
        launch(32'h180, 2, 4'h2, 0, 1, 0, 4'h4);
        wait_done("R8c");
        chk("R8 write mismatch refused", 32'(prot_err), 1);
        chk("R8 no write on mismatch", 32'(wr_cnt - w0), 0);
        src_n = 0; src_p = 0;
        ngot = 0;
        launch(32'h184, 2, 4'h1, 0, 0, 0, 4'h4);
        wait_done("R8d");
        chk("R8 read mismatch without fetch-protect allowed", {30'd0, prot_err, chan_end}, 1);
        launch(32'h900, 2, 4'h1, 0, 0, 0, 4'h4);
        wait_done("R8e");
        chk("R8 fetch-protected read refused", 32'(prot_err), 1);
        prot_en = 0;

        // R9 out of range
        w0 = acc_cnt;
        launch(MEMB, 2, 4'h1, 0, 0, 0, 4'h0);
        wait_done("R9");
        chk("R9 program check", {30'd0, prog_chk, prot_err}, 2);
        chk("R9 no access", 32'(acc_cnt - w0), 0);

        // R10 zero count
        launch(32'h200, 0, 4'h1, 0, 0, 0, 4'h0);
        wait_done("R10");
        chk("R10 zero count", 32'(prog_chk), 1);
        chk("R10 no access", 32'(acc_cnt - w0), 0);

        // random mix
        for (int k = 0; k < 24; k++) begin
            d = int'($urandom % 3);
            c = 1 + int'($urandom % 14);
            a = 32'h040 + int'($urandom % 32'h700);
            case (d)
                0: run_out("R2 random", a, c);
                1: run_in("R3 random", a, c, 0, 0, 1, 0);
                default: run_in("R4 random", a, c, 1, 0, 1, 0);
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule